// File: doc/BRIEF.md
# Vector Crypto Operand Alignment Checker

This block sits in the decode stage of a vector unit and decides whether a vector crypto instruction that works on element groups may issue. It takes the decoded register indices of the destination and the two sources, a flag telling the scalar-group (.vs) form apart from the vector-vector form, a flag saying whether the vs1 field names a register, and the group-multiplier field of the current vector type. The result is an illegal-instruction flag and a cause vector. The check is the same for every element-group instruction class: block cipher rounds, both hash-schedule widths, the other block cipher, the other hash, and the field multiply.

Operands that hold vector element groups must start on a register index that is a multiple of the register-group size set by the multiplier. Fractional multipliers add no constraint. In the .vs form the vs2 operand is one wide scalar element group of EGW bits. Its group size is EGW/VLEN registers (at least one), whatever the multiplier says, so one instruction obeys two alignment rules at once. A group that would run past register 31 is also rejected. The outputs are combinational and are forced to zero while the valid strobe is low.

Top module: `vcra_align_check`

## Requirements
- R1: While valid_i is low, illegal_o is 0 and cause_o is 3'b000, whatever the other inputs are.
- R2: vlmul_i encodings 3'b000, 3'b001, 3'b010 and 3'b011 give group sizes 1, 2, 4 and 8. A vd_i that is not a multiple of the group size sets cause_o[0].
- R3: vlmul_i encodings 3'b101, 3'b110, 3'b111 (fractional) and 3'b100 (reserved) give a group size of 1, so cause_o[0] is never set.
- R4: vs1_i is checked against the group size only when vs1_en_i is 1 and vs_form_i is 0. Otherwise its value has no effect on the outputs.
- R5: In the vector-vector form (vs_form_i = 0), vs2_i is checked against the multiplier group size and a misaligned value sets cause_o[0].
- R6: In the .vs form (vs_form_i = 1), vs2_i is checked against the scalar group size EGW/VLEN (minimum 1) and never against the multiplier. A misaligned value sets cause_o[1]. vd_i is still checked against the multiplier.
- R7: With VLEN >= EGW, the scalar group is one register, so no vs2_i value sets cause_o[1].
- R8: With EGW = 128, VLEN = 64 needs an even vs2_i and VLEN = 32 needs a multiple of 4 in the .vs form. Any other value sets cause_o[1].
- R9: cause_o[2] is set when a checked operand's group, from its index through index + size - 1, would go past register 31. A group that ends exactly at 31 is legal.
- R10: illegal_o is 1 exactly when any bit of cause_o is 1. The bits are independent, so the multiplier and scalar-group causes may be reported together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| valid_i | input | 1 | Decoded instruction present this cycle |
| vlmul_i | input | 3 | Register-group multiplier field of the vector type |
| vd_i | input | 5 | Destination register index |
| vs1_i | input | 5 | First source register index |
| vs2_i | input | 5 | Second source register index |
| vs1_en_i | input | 1 | vs1 field names a vector register operand |
| vs_form_i | input | 1 | 1: scalar-element-group (.vs) form, 0: vector-vector form |
| illegal_o | output | 1 | Instruction must trap as illegal |
| cause_o | output | 3 | bit0 multiplier misalignment, bit1 scalar-group misalignment, bit2 group past last register |

## Verification
The vector table steps through each multiplier with aligned and misaligned indices on each operand in turn. This separates a fault in the vd, vs1 and vs2 paths from a fault in the group-size decode. Pairs that differ only in vs1_en_i or vs_form_i show whether an operand is gated correctly. Three instances with VLEN 128, 64 and 32 receive the same .vs stimulus, so the scalar rule is seen to follow VLEN rather than the multiplier. Indices near 31 separate the group-overrun rule from plain misalignment.

// File: rtl/vcra_pkg.sv
package vcra_pkg;

  localparam int REG_IDX_W = 5;
  localparam int NUM_VREGS = 32;
  localparam int LOG2_W    = 3;
  localparam int CAUSE_W   = 3;
  localparam int CAUSE_LMUL  = 0;
  localparam int CAUSE_SGRP  = 1;
  localparam int CAUSE_BOUND = 2;

  typedef logic [REG_IDX_W-1:0] vreg_idx_t;
  typedef logic [LOG2_W-1:0]    grp_log2_t;

  typedef enum logic [2:0] {
    GRP_X1   = 3'b000,
    GRP_X2   = 3'b001,
    GRP_X4   = 3'b010,
    GRP_X8   = 3'b011,
    GRP_RSV  = 3'b100,
    GRP_F8   = 3'b101,
    GRP_F4   = 3'b110,
    GRP_F2   = 3'b111
  } grp_mul_e;

  // low log2 bits of the index must be zero
  function automatic logic idx_misaligned(vreg_idx_t idx, grp_log2_t lg);
    logic [REG_IDX_W:0] mask;
    mask = (REG_IDX_W'(1) + 6'd0) << lg;
    mask = mask - 6'd1;
    return (idx & mask[REG_IDX_W-1:0]) != '0;
  endfunction

  // last register of the group must not exceed the top index
  function automatic logic grp_overruns(vreg_idx_t idx, grp_log2_t lg);
    logic [REG_IDX_W+1:0] last;
    last = {2'b00, idx} + ((7'd1 << lg) - 7'd1);
    return last > 7'(NUM_VREGS - 1);
  endfunction

endpackage

// File: rtl/vcra_lmul_decode.sv
module vcra_lmul_decode
  import vcra_pkg::*;
(
  input  logic [2:0] vlmul_i,
  output grp_log2_t  log2_o,
  output logic       frac_o
);

  always_comb begin
    log2_o = '0;
    frac_o = 1'b0;
    unique case (grp_mul_e'(vlmul_i))
      GRP_X1:  log2_o = 3'd0;
      GRP_X2:  log2_o = 3'd1;
      GRP_X4:  log2_o = 3'd2;
      GRP_X8:  log2_o = 3'd3;
      default: frac_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/vcra_group_check.sv
module vcra_group_check
  import vcra_pkg::*;
(
  input  vreg_idx_t idx_i,
  input  grp_log2_t log2_i,
  input  logic      en_i,
  output logic      misalign_o,
  output logic      overrun_o
);

  assign misalign_o = en_i & idx_misaligned(idx_i, log2_i);
  assign overrun_o  = en_i & grp_overruns(idx_i, log2_i);

endmodule

// File: rtl/vcra_align_check.sv
module vcra_align_check
  import vcra_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int EGW  = 128
) (
  input  logic         valid_i,
  input  logic [2:0]   vlmul_i,
  input  logic [4:0]   vd_i,
  input  logic [4:0]   vs1_i,
  input  logic [4:0]   vs2_i,
  input  logic         vs1_en_i,
  input  logic         vs_form_i,
  output logic         illegal_o,
  output logic [2:0]   cause_o
);

  localparam int SG_REGS = (EGW > VLEN) ? (EGW / VLEN) : 1;
  localparam int SG_LOG2 = $clog2(SG_REGS);
  localparam int NOPS    = 3;

  grp_log2_t lmul_log2;
  logic      lmul_frac;

  vcra_lmul_decode u_dec (
    .vlmul_i (vlmul_i),
    .log2_o  (lmul_log2),
    .frac_o  (lmul_frac)
  );

  vreg_idx_t       op_idx [NOPS];
  logic [NOPS-1:0] op_en;
  logic [NOPS-1:0] op_mis;
  logic [NOPS-1:0] op_ovr;

  assign op_idx[0] = vd_i;
  assign op_idx[1] = vs1_i;
  assign op_idx[2] = vs2_i;
  assign op_en[0]  = 1'b1;
  assign op_en[1]  = vs1_en_i & ~vs_form_i;
  assign op_en[2]  = ~vs_form_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_lmul_op
    vcra_group_check u_grp (
      .idx_i      (op_idx[g]),
      .log2_i     (lmul_log2),
      .en_i       (op_en[g]),
      .misalign_o (op_mis[g]),
      .overrun_o  (op_ovr[g])
    );
  end

  logic sgrp_mis_w;
  logic sgrp_ovr_w;

  if (SG_LOG2 > 0) begin : g_sgrp
    vcra_group_check u_sgrp (
      .idx_i      (vs2_i),
      .log2_i     (grp_log2_t'(SG_LOG2)),
      .en_i       (vs_form_i),
      .misalign_o (sgrp_mis_w),
      .overrun_o  (sgrp_ovr_w)
    );
  end else begin : g_no_sgrp
    assign sgrp_mis_w = 1'b0;
    assign sgrp_ovr_w = 1'b0;
  end

  // named events for the checker
  logic lmul_mis_w;
  logic bound_w;
  assign lmul_mis_w = (|op_mis) & ~lmul_frac;
  assign bound_w    = (|op_ovr) | sgrp_ovr_w;

  always_comb begin
    cause_o = '0;
    if (valid_i) begin
      cause_o[CAUSE_LMUL]  = lmul_mis_w;
      cause_o[CAUSE_SGRP]  = sgrp_mis_w;
      cause_o[CAUSE_BOUND] = bound_w;
    end
  end

  assign illegal_o = |cause_o;

endmodule

// File: rtl/vcra_align_sva.sv
module vcra_align_sva #(
  parameter int VLEN = 128,
  parameter int EGW  = 128
) (
  input logic       valid_i,
  input logic [2:0] vlmul_i,
  input logic [4:0] vd_i,
  input logic       vs_form_i,
  input logic       lmul_frac,
  input logic       illegal_o,
  input logic [2:0] cause_o
);

  int grp_sz;
  always_comb begin
    case (vlmul_i)
      3'b001:  grp_sz = 2;
      3'b010:  grp_sz = 4;
      3'b011:  grp_sz = 8;
      default: grp_sz = 1;
    endcase
  end

  always_comb begin
    AST_IDLE_QUIET: assert (valid_i || (cause_o == 3'b000 && !illegal_o)) else $error("idle output"); // R1
    AST_VD_ALIGN: assert (!valid_i || (int'(vd_i) % grp_sz) == 0 || cause_o[0]) else $error("vd misalign missed"); // R2
    AST_FRAC_FREE: assert (!(lmul_frac && vlmul_i[2]) || !cause_o[0]) else $error("fractional flagged"); // R3
    AST_SGRP_VS_ONLY: assert (vs_form_i || !cause_o[1]) else $error("scalar cause in vv form"); // R6
    AST_WIDE_SGRP: assert (VLEN < EGW || !cause_o[1]) else $error("scalar cause with wide VLEN"); // R7
    AST_BOUND_NEEDS_MIS: assert (!cause_o[2] || cause_o[0] || cause_o[1]) else $error("overrun on aligned group"); // R9
    AST_FLAG_AGREES: assert (illegal_o == (cause_o != 3'b000)) else $error("flag disagrees"); // R10
  end

endmodule

bind vcra_align_check vcra_align_sva #(.VLEN(VLEN), .EGW(EGW)) u_sva (
  .valid_i   (valid_i),
  .vlmul_i   (vlmul_i),
  .vd_i      (vd_i),
  .vs_form_i (vs_form_i),
  .lmul_frac (lmul_frac),
  .illegal_o (illegal_o),
  .cause_o   (cause_o)
);

// File: tb/sim_vcra_align_check.sv
module sim_vcra_align_check;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       valid, vs1_en, vs_form;
  logic [2:0] vlmul;
  logic [4:0] vd, vs1, vs2;
  logic       ill0, ill1, ill2;
  logic [2:0] c0, c1, c2;

  int n_run  = 0;
  int n_fail = 0;

  vcra_align_check #(.VLEN(128), .EGW(128)) u0 (
    .valid_i(valid), .vlmul_i(vlmul), .vd_i(vd), .vs1_i(vs1), .vs2_i(vs2),
    .vs1_en_i(vs1_en), .vs_form_i(vs_form), .illegal_o(ill0), .cause_o(c0));
  vcra_align_check #(.VLEN(64), .EGW(128)) u1 (
    .valid_i(valid), .vlmul_i(vlmul), .vd_i(vd), .vs1_i(vs1), .vs2_i(vs2),
    .vs1_en_i(vs1_en), .vs_form_i(vs_form), .illegal_o(ill1), .cause_o(c1));
  vcra_align_check #(.VLEN(32), .EGW(128)) u2 (
    .valid_i(valid), .vlmul_i(vlmul), .vd_i(vd), .vs1_i(vs1), .vs2_i(vs2),
    .vs1_en_i(vs1_en), .vs_form_i(vs_form), .illegal_o(ill2), .cause_o(c2));

  typedef struct packed {
    logic [3:0] req;
    logic       v;
    logic [2:0] lm;
    logic [4:0] d;
    logic [4:0] s1;
    logic [4:0] s2;
    logic       en;
    logic       vsf;
    logic [2:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam logic [27:0] VECS [NV] = '{
    {4'd1,  1'b0, 3'b011, 5'd1,  5'd3,  5'd5,  1'b1, 1'b0, 3'b000}, // R1
    {4'd2,  1'b1, 3'b000, 5'd3,  5'd5,  5'd7,  1'b1, 1'b0, 3'b000}, // R2
    {4'd2,  1'b1, 3'b001, 5'd2,  5'd4,  5'd6,  1'b1, 1'b0, 3'b000}, // R2
    {4'd2,  1'b1, 3'b001, 5'd3,  5'd4,  5'd6,  1'b1, 1'b0, 3'b001}, // R2
    {4'd2,  1'b1, 3'b010, 5'd8,  5'd12, 5'd16, 1'b1, 1'b0, 3'b000}, // R2
    {4'd4,  1'b1, 3'b010, 5'd8,  5'd13, 5'd16, 1'b1, 1'b0, 3'b001}, // R4
    {4'd4,  1'b1, 3'b010, 5'd8,  5'd13, 5'd16, 1'b0, 1'b0, 3'b000}, // R4
    {4'd5,  1'b1, 3'b010, 5'd8,  5'd4,  5'd18, 1'b1, 1'b0, 3'b001}, // R5
    {4'd2,  1'b1, 3'b011, 5'd24, 5'd16, 5'd8,  1'b1, 1'b0, 3'b000}, // R2
    {4'd9,  1'b1, 3'b011, 5'd25, 5'd16, 5'd8,  1'b1, 1'b0, 3'b101}, // R9
    {4'd9,  1'b1, 3'b011, 5'd31, 5'd16, 5'd8,  1'b1, 1'b0, 3'b101}, // R9
    {4'd3,  1'b1, 3'b111, 5'd3,  5'd5,  5'd7,  1'b1, 1'b0, 3'b000}, // R3
    {4'd3,  1'b1, 3'b101, 5'd31, 5'd5,  5'd7,  1'b1, 1'b0, 3'b000}, // R3
    {4'd3,  1'b1, 3'b100, 5'd1,  5'd5,  5'd7,  1'b1, 1'b0, 3'b000}, // R3
    {4'd7,  1'b1, 3'b010, 5'd4,  5'd3,  5'd5,  1'b1, 1'b1, 3'b000}, // R7 and R4
    {4'd6,  1'b1, 3'b010, 5'd6,  5'd3,  5'd5,  1'b1, 1'b1, 3'b001}, // R6
    {4'd9,  1'b1, 3'b010, 5'd4,  5'd0,  5'd30, 1'b0, 1'b0, 3'b101}, // R9
    {4'd9,  1'b1, 3'b001, 5'd30, 5'd31, 5'd0,  1'b1, 1'b0, 3'b101}, // R9
    {4'd9,  1'b1, 3'b001, 5'd30, 5'd28, 5'd30, 1'b1, 1'b0, 3'b000}  // R9
  };

  task automatic chk(input string req, input string what,
                     input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // illegal flag must equal OR of expected cause (R10)
  task automatic chk_all(input string req, input logic [2:0] e0,
                         input logic [2:0] e1, input logic [2:0] e2);
    chk(req, "u0 cause", c0, e0);
    chk("R10", "u0 illegal", {2'b00, ill0}, {2'b00, |e0});
    chk(req, "u1 cause", c1, e1);
    chk(req, "u2 cause", c2, e2);
  endtask

  task automatic drive(input logic v, input logic [2:0] lm, input logic [4:0] d,
                       input logic [4:0] s1, input logic [4:0] s2,
                       input logic en, input logic vsf);
    @(negedge clk);
    valid = v; vlmul = lm; vd = d; vs1 = s1; vs2 = s2; vs1_en = en; vs_form = vsf;
    #2;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    valid = 1'b0; vlmul = 3'b011; vd = 5'd3; vs1 = 5'd3; vs2 = 5'd3;
    vs1_en = 1'b1; vs_form = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "reset u0", c0, 3'b000);
    chk("R1", "reset illegal", {2'b00, ill0}, 3'b000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t t;
      t = vec_t'(VECS[i]);
      drive(t.v, t.lm, t.d, t.s1, t.s2, t.en, t.vsf);
      chk($sformatf("R%0d", t.req), $sformatf("vec %0d cause", i), c0, t.exp);
      chk("R10", $sformatf("vec %0d illegal", i), {2'b00, ill0}, {2'b00, |t.exp});
    end

    // scalar group follows VLEN, not multiplier: R8
    drive(1'b1, 3'b000, 5'd0, 5'd0, 5'd3, 1'b0, 1'b1);
    chk_all("R8", 3'b000, 3'b010, 3'b010);
    drive(1'b1, 3'b000, 5'd0, 5'd0, 5'd2, 1'b0, 1'b1);
    chk_all("R8", 3'b000, 3'b000, 3'b010);
    drive(1'b1, 3'b000, 5'd0, 5'd0, 5'd4, 1'b0, 1'b1);
    chk_all("R8", 3'b000, 3'b000, 3'b000);
    // scalar group past last register: R9
    drive(1'b1, 3'b000, 5'd0, 5'd0, 5'd31, 1'b0, 1'b1);
    chk_all("R9", 3'b000, 3'b110, 3'b110);
    drive(1'b1, 3'b000, 5'd0, 5'd0, 5'd28, 1'b0, 1'b1);
    chk_all("R9", 3'b000, 3'b000, 3'b000);
    // both causes at once: R10
    drive(1'b1, 3'b001, 5'd3, 5'd0, 5'd1, 1'b0, 1'b1);
    chk_all("R10", 3'b001, 3'b011, 3'b011);
    // multiplier 8 does not widen scalar group: R6
    drive(1'b1, 3'b011, 5'd8, 5'd0, 5'd2, 1'b0, 1'b1);
    chk_all("R6", 3'b000, 3'b000, 3'b010);
    // same vs2 in vv form uses multiplier rule only: R5
    drive(1'b1, 3'b011, 5'd8, 5'd0, 5'd2, 1'b0, 1'b0);
    chk_all("R5", 3'b001, 3'b001, 3'b001);
    // strobe low masks everything: R1
    drive(1'b0, 3'b001, 5'd3, 5'd0, 5'd31, 1'b1, 1'b1);
    chk_all("R1", 3'b000, 3'b000, 3'b000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule